// File: doc/BRIEF.md
# Soft-Start and Fault Supervisor for a PWM Controller

This block decides when a pulse-width modulator may run and how wide its pulses may be. It takes sampled codes for the supply rail, the internal reference and a shutdown-sense input, plus the duty command from the error amplifier. All voltage codes use units of 0.1 V. A lockout holds the modulator off until the supply is healthy, with hysteresis. A soft-start accumulator then lets the duty command grow slowly from zero.

The duty command sent on to the modulator is the smaller of the error-amplifier command and the soft-start value. The soft-start ramp stops at a ceiling, so the ceiling also sets a maximum duty. Any lockout or shutdown event empties the accumulator at once. After a hard fault clears, the ramp starts again from zero, and this hiccup restart repeats for as long as faults keep returning.

The lockout releases the driver output-enable, which puts the gate drivers in high impedance. A shutdown event only forces the pulses off and keeps the drivers enabled. A two-stage synchronizer releases the asynchronous reset, so the first functional clock edge is the third one after `rst_n` rises.

Top module: `ssfs_supervisor`

## Requirements
- R1: While the internal reset is held, and after it, until the supply has been qualified, `duty_cmd` is 0, `force_off` is 1 and `drv_oe` is 0.
- R2: Lockout is entered after `supply_code` < UV_OFF (default 92) on UV_DG (default 3) consecutive registered samples. It takes effect at the ports UV_DG+2 cycles after the dip begins: `drv_oe`=0, `force_off`=1, `duty_cmd`=0. A dip of fewer samples has no effect.
- R3: Lockout is left only after `supply_code` > UV_OFF+UV_HYST (default 98) on UV_DG consecutive samples. Codes from UV_OFF to UV_OFF+UV_HYST neither enter nor leave lockout.
- R4: The modulator runs only while the registered compare `vref_code` > REF_GOOD (default 40) is true. This compare has no deglitch, so running stops two cycles after the reference drops.
- R5: After `sd_code` > SD_TRIP (default 14) on UV_DG consecutive samples, `duty_cmd`=0 and `force_off`=1 within UV_DG+2 cycles, while `drv_oe` stays 1.
- R6: While running, the soft-start value rises from zero by SS_STEP (default 8) once every SS_PRESC (default 4) cycles and saturates at SS_CEIL (default 200). `duty_cmd` is therefore never above SS_CEIL.
- R7: While running, `duty_cmd` one cycle later equals min(`ea_duty`, soft-start value).
- R8: Each time a shutdown event clears (`sd_code` <= SD_TRIP for UV_DG samples), the ramp restarts from zero. There is no limit on the number of restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_code | input | CODE_W | Supply rail sample, 0.1 V per code |
| vref_code | input | CODE_W | Reference rail sample, 0.1 V per code |
| sd_code | input | CODE_W | Shutdown-sense sample, 0.1 V per code |
| ea_duty | input | DUTY_W | Duty command from the error amplifier |
| duty_cmd | output | DUTY_W | Clamped duty command to the modulator |
| force_off | output | 1 | High when all output pulses must be suppressed |
| drv_oe | output | 1 | Gate-driver output enable; low selects high impedance |

## Verification
Faults in the internal state show up at the ports quickly. If the soft-start accumulator is not emptied on a fault, or steps at the wrong rate, `duty_cmd` departs from the arithmetic staircase within one prescaler period of a restart. If a deglitch counter is off by one, the enable or force edge lands one cycle early or late against the exact UV_DG+2 latency. A short dip of UV_DG-1 samples then also toggles `drv_oe`. If the hysteresis compare is wrong, an in-band supply code trips the lockout, or releases it, within UV_DG+2 cycles.

// File: rtl/ssfs_pkg.sv
package ssfs_pkg;

  // Operating condition of the supervisor, ordered by precedence
  typedef enum logic [1:0] {
    ST_LOCK     = 2'd0,
    ST_FAULT    = 2'd1,
    ST_WAIT_REF = 2'd2,
    ST_RUN      = 2'd3
  } ssfs_state_e;

endpackage

// File: rtl/ssfs_deglitch.sv
// Two-way qualified flag: moves to 1 after N consecutive set samples and
// back to 0 after N consecutive clear samples.
module ssfs_deglitch #(
  parameter int  N         = 3,
  parameter bit  RST_STATE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic state_o
);

  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          state_q, state_d;
  logic          toward;

  always_comb begin
    toward  = state_q ? clr_i : set_i;
    cnt_d   = '0;
    state_d = state_q;
    if (toward) begin
      if (cnt_q == LAST) begin
        state_d = ~state_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      state_q <= RST_STATE;
    end else begin
      cnt_q   <= cnt_d;
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/ssfs_ramp.sv
// Soft-start accumulator: emptied when not running, otherwise climbs by STEP
// once per PRESC cycles and saturates at CEIL.
module ssfs_ramp #(
  parameter int DUTY_W = 8,
  parameter int STEP   = 8,
  parameter int PRESC  = 4,
  parameter int CEIL   = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  output logic [DUTY_W-1:0] ss_o
);

  localparam logic [DUTY_W:0] STEP_C = (DUTY_W+1)'(STEP);
  localparam logic [DUTY_W:0] CEIL_C = (DUTY_W+1)'(CEIL);

  logic [DUTY_W-1:0] ss_q, ss_d;
  logic [DUTY_W:0]   sum;
  logic              tick;

  generate
    if (PRESC <= 1) begin : g_no_presc
      assign tick = run_i;
    end else begin : g_presc
      localparam int PW = $clog2(PRESC);
      localparam logic [PW-1:0] PLAST = PW'(PRESC - 1);
      logic [PW-1:0] pc_q, pc_d;

      always_comb begin
        pc_d = '0;
        if (run_i && (pc_q != PLAST)) begin
          pc_d = pc_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pc_q <= '0;
        end else begin
          pc_q <= pc_d;
        end
      end

      assign tick = run_i && (pc_q == PLAST);
    end
  endgenerate

  always_comb begin
    sum = {1'b0, ss_q} + STEP_C;
    if (!run_i) begin
      ss_d = '0;
    end else if (tick) begin
      ss_d = (sum > CEIL_C) ? CEIL_C[DUTY_W-1:0] : sum[DUTY_W-1:0];
    end else begin
      ss_d = ss_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_q <= '0;
    end else begin
      ss_q <= ss_d;
    end
  end

  assign ss_o = ss_q;

endmodule

// File: rtl/ssfs_supervisor.sv
module ssfs_supervisor
  import ssfs_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int DUTY_W   = 8,
  parameter int UV_OFF   = 92,
  parameter int UV_HYST  = 6,
  parameter int REF_GOOD = 40,
  parameter int SD_TRIP  = 14,
  parameter int UV_DG    = 3,
  parameter int SS_STEP  = 8,
  parameter int SS_PRESC = 4,
  parameter int SS_CEIL  = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] supply_code,
  input  logic [CODE_W-1:0] vref_code,
  input  logic [CODE_W-1:0] sd_code,
  input  logic [DUTY_W-1:0] ea_duty,
  output logic [DUTY_W-1:0] duty_cmd,
  output logic              force_off,
  output logic              drv_oe
);

  localparam logic [CODE_W-1:0] LO_TH  = CODE_W'(UV_OFF);
  localparam logic [CODE_W-1:0] HI_TH  = CODE_W'(UV_OFF + UV_HYST);
  localparam logic [CODE_W-1:0] REF_TH = CODE_W'(REF_GOOD);
  localparam logic [CODE_W-1:0] SD_TH  = CODE_W'(SD_TRIP);

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // Registered threshold compares
  logic sup_lo_q, sup_hi_q, ref_ok_q, sd_hi_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sup_lo_q <= 1'b0;
      sup_hi_q <= 1'b0;
      ref_ok_q <= 1'b0;
      sd_hi_q  <= 1'b0;
    end else begin
      sup_lo_q <= supply_code < LO_TH;
      sup_hi_q <= supply_code > HI_TH;
      ref_ok_q <= vref_code > REF_TH;
      sd_hi_q  <= sd_code > SD_TH;
    end
  end

  // Qualified lockout and shutdown flags
  logic uv_lock, sd_fault;

  ssfs_deglitch #(.N(UV_DG), .RST_STATE(1'b1)) i_uv_dg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_i   (sup_lo_q),
    .clr_i   (sup_hi_q),
    .state_o (uv_lock)
  );

  ssfs_deglitch #(.N(UV_DG), .RST_STATE(1'b0)) i_sd_dg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_i   (sd_hi_q),
    .clr_i   (~sd_hi_q),
    .state_o (sd_fault)
  );

  // Operating condition
  ssfs_state_e st;
  logic        run;

  always_comb begin
    if (uv_lock) begin
      st = ST_LOCK;
    end else if (sd_fault) begin
      st = ST_FAULT;
    end else if (!ref_ok_q) begin
      st = ST_WAIT_REF;
    end else begin
      st = ST_RUN;
    end
    run = (st == ST_RUN);
  end

  // Soft-start accumulator
  logic [DUTY_W-1:0] ss_q;

  ssfs_ramp #(
    .DUTY_W (DUTY_W),
    .STEP   (SS_STEP),
    .PRESC  (SS_PRESC),
    .CEIL   (SS_CEIL)
  ) i_ramp (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run_i (run),
    .ss_o  (ss_q)
  );

  // Output stage
  logic [DUTY_W-1:0] duty_d, duty_q;
  logic              foff_d, foff_q, oe_d, oe_q;

  always_comb begin
    duty_d = '0;
    if (run) begin
      duty_d = (ea_duty < ss_q) ? ea_duty : ss_q;
    end
    foff_d = ~run;
    oe_d   = (st != ST_LOCK);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      duty_q <= '0;
      foff_q <= 1'b1;
      oe_q   <= 1'b0;
    end else begin
      duty_q <= duty_d;
      foff_q <= foff_d;
      oe_q   <= oe_d;
    end
  end

  assign duty_cmd  = duty_q;
  assign force_off = foff_q;
  assign drv_oe    = oe_q;

endmodule

// File: rtl/ssfs_checker.sv
module ssfs_checker #(
  parameter int DUTY_W  = 8,
  parameter int SS_STEP = 8,
  parameter int SS_CEIL = 200
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DUTY_W-1:0] duty_cmd,
  input logic              force_off,
  input logic              drv_oe,
  input logic [DUTY_W-1:0] ea_duty,
  input logic [DUTY_W-1:0] ss_q
);

  // R2: drivers released implies no duty
  p_lock_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_oe |-> (duty_cmd == '0));

  // R5: forced off implies no duty
  p_fault_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |-> (duty_cmd == '0));

  // R6: never above the ceiling
  p_ceiling_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(duty_cmd) <= SS_CEIL);

  // R6: accumulator never climbs more than one step per cycle
  p_ramp_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ss_q) <= int'($past(ss_q)) + SS_STEP);

  // R7: running duty never exceeds the previous error command
  p_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !force_off |-> (duty_cmd <= $past(ea_duty)));

endmodule

bind ssfs_supervisor ssfs_checker #(
  .DUTY_W  (DUTY_W),
  .SS_STEP (SS_STEP),
  .SS_CEIL (SS_CEIL)
) i_ssfs_checker (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .duty_cmd  (duty_cmd),
  .force_off (force_off),
  .drv_oe    (drv_oe),
  .ea_duty   (ea_duty),
  .ss_q      (ss_q)
);

// File: tb/test_ssfs_supervisor.sv
`timescale 1ns/1ps
module test_ssfs_supervisor;

  localparam int DG    = 3;
  localparam int STEP  = 8;
  localparam int PRESC = 4;
  localparam int CEIL  = 200;

  logic       clk;
  logic       rst_n;
  logic [7:0] supply_code, vref_code, sd_code, ea_duty;
  logic [7:0] duty_cmd;
  logic       force_off, drv_oe;

  int checks = 0;
  int errors = 0;

  ssfs_supervisor i_ssfs_supervisor (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_code (supply_code),
    .vref_code   (vref_code),
    .sd_code     (sd_code),
    .ea_duty     (ea_duty),
    .duty_cmd    (duty_cmd),
    .force_off   (force_off),
    .drv_oe      (drv_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int d, input int f, input int oe);
    chk(req, "duty_cmd", int'(duty_cmd), d);
    chk(req, "force_off", int'(force_off), f);
    chk(req, "drv_oe", int'(drv_oe), oe);
  endtask

  function automatic int min3(input int a, input int b, input int c);
    int m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

  // Stimulus already applied; run starts so that force_off clears at cycle d
  task automatic follow_ramp(input string req, input int d, input int ea, input int n);
    for (int t = 1; t <= n; t++) begin
      int ed, ef;
      tick();
      if (t < d) begin
        ed = 0;
        ef = 1;
      end else begin
        ed = min3(ea, CEIL, STEP * ((t - d) / PRESC));
        ef = 0;
      end
      chk(req, "ramp duty_cmd", int'(duty_cmd), ed);
      chk(req, "ramp force_off", int'(force_off), ef);
      if (t >= d) chk(req, "ramp drv_oe", int'(drv_oe), 1);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    supply_code = 8'd0; vref_code = 8'd0; sd_code = 8'd0; ea_duty = 8'd0;
    repeat (3) tick();
    chk_out("R1", 0, 1, 0);
    rst_n = 1'b1;
    tick(); tick();
    chk_out("R1", 0, 1, 0);

    // Power-up with wide error command: ramp saturates at ceiling (R6, R3)
    supply_code = 8'd120; vref_code = 8'd51; ea_duty = 8'd255;
    follow_ramp("R6", DG + 2, 255, 120);

    // Error command below ramp passes through (R7)
    ea_duty = 8'd100; tick(); chk_out("R7", 100, 0, 1);
    ea_duty = 8'd37;  tick(); chk_out("R7", 37, 0, 1);
    ea_duty = 8'd200; tick(); chk_out("R7", 200, 0, 1);
    ea_duty = 8'd37;  tick();

    // In-band supply does not trip (R3)
    supply_code = 8'd95;
    for (int i = 0; i < 20; i++) begin
      tick(); chk_out("R3", 37, 0, 1);
    end

    // Dip of DG-1 samples is ignored (R2)
    supply_code = 8'd91; tick(); tick();
    supply_code = 8'd120;
    for (int i = 0; i < 10; i++) begin
      tick(); chk_out("R2", 37, 0, 1);
    end

    // Sustained dip enters lockout at DG+2 (R2)
    supply_code = 8'd91;
    repeat (DG + 1) tick();
    chk_out("R2", 37, 0, 1);
    tick();
    chk_out("R2", 0, 1, 0);

    // In-band supply does not release (R3)
    supply_code = 8'd95;
    for (int i = 0; i < 20; i++) begin
      tick(); chk_out("R3", 0, 1, 0);
    end
    supply_code = 8'd98;
    for (int i = 0; i < 10; i++) begin
      tick(); chk_out("R3", 0, 1, 0);
    end

    // Above hysteresis band: release and fresh ramp (R3)
    supply_code = 8'd99; ea_duty = 8'd255;
    follow_ramp("R3", DG + 2, 255, 40);

    // Reference not good stops running two cycles later (R4)
    vref_code = 8'd40;
    tick(); chk("R4", "force_off early", int'(force_off), 0);
    tick(); chk_out("R4", 0, 1, 1);
    for (int i = 0; i < 8; i++) begin
      tick(); chk_out("R4", 0, 1, 1);
    end
    vref_code = 8'd41;
    follow_ramp("R4", 2, 255, 40);

    // Repeated shutdown with hiccup restart (R5, R8)
    for (int k = 0; k < 3; k++) begin
      sd_code = 8'd15;
      repeat (DG + 1) tick();
      chk("R5", "force_off before trip", int'(force_off), 0);
      tick();
      chk_out("R5", 0, 1, 1);
      for (int i = 0; i < 6; i++) begin
        tick(); chk_out("R5", 0, 1, 1);
      end
      sd_code = 8'd14;
      ea_duty = (k == 1) ? 8'd60 : 8'd255;
      follow_ramp("R8", DG + 2, int'(ea_duty), 60);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule